// File: doc/BRIEF.md
# Buck Converter Start-up and Short-Circuit Supervisor

This block sequences power-up and protection for a synchronous step-down converter controller. A one-clock pulse arrives once per switching period. On every such pulse during start-up the block raises a 10-bit reference code by one, from zero to full scale, and the error amplifier uses that code as its target. A single gate-enable bit turns both power drivers on or off. Two more outputs serve the external feedback-undervoltage comparator: a threshold code equal to half the present reference, and an arm bit that stays low for the first half of the ramp.

Three inputs control the block. Supply-good reports that the supply is above its lockout level, and it resets everything while low. A shutdown request holds the ramp at zero and lets the controller restart cleanly once it is released. A short, meaning the undervoltage flag held for a filtered number of switching periods while the check is armed, latches a fault. Only a full low-then-high cycle of supply-good clears that fault. Supply-good and the shutdown request are synchronized inside the block. The undervoltage flag is taken to be synchronous to the clock and is sampled only on tick pulses.

Top module: `buck_startup_guard`

## Requirements
- R1: After reset the gate enable, fault, done and arm outputs are 0 and the reference and threshold codes are 0.
- R2: While supply-good is low the gate enable is 0 and the reference code is 0, and tick pulses do not advance it.
- R3: In soft start the reference code rises by exactly 1 on each tick pulse, starting from 0. A tick at 1023 enters run, where the code stays at 1023 and the done output is 1. The done output is 0 in every other state.
- R4: While the shutdown request is high the gate enable and done outputs are 0 and the reference code is 0. After release a new ramp starts from 0 with the gate enable at 1.
- R5: The arm output is 0 while the reference code is below 512 in soft start, and an undervoltage flag then has no effect. The arm output is 1 from code 512 onward and in run.
- R6: The threshold output equals the reference code shifted right by one bit (floor of half).
- R7: A fault trips on the FILT_N-th consecutive armed tick (default 8) that sees the undervoltage flag high. An armed tick with the flag low restarts the count.
- R8: In fault the gate enable, arm and done outputs are 0, the fault output is 1 and the reference code is 0. Neither the shutdown request nor a cleared flag ends the fault. Only supply-good going low ends it, and when supply-good returns high a new ramp starts from 0.
- R9: Supply-good and the shutdown request pass through two synchronizing flops. Their effect appears at the outputs on the third clock edge after they change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cycTick | input | 1 | One-clock pulse per switching period |
| supplyOk | input | 1 | Supply above lockout level (asynchronous) |
| offReq | input | 1 | Shutdown request (asynchronous) |
| uvFlag | input | 1 | Feedback below threshold, synchronous to clk |
| refCode | output | 10 | Reference code for the error amplifier |
| uvThresh | output | 10 | Undervoltage threshold code, half of refCode |
| uvArmed | output | 1 | Undervoltage check enabled |
| drvEn | output | 1 | Gate enable for both power drivers |
| faultOut | output | 1 | Latched short-circuit fault |
| rampDone | output | 1 | Soft start complete, in run |

## Verification
A wrong state shows up at the ports within one tick. If the state machine sits in the wrong state, the gate enable or done bit disagrees on the third edge after an input change. If the ramp counter drops or repeats a step, refCode is off by one right after the pulse that should have moved it. A wrong filter count or arm boundary moves the fault trip by at least one tick, so the bench checks the tick just before the expected trip as well as the trip tick itself. A fault latch that clears too easily shows as drvEn returning without a supply-good cycle.

// File: rtl/bsg_pkg.sv
package bsg_pkg;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_SOFT  = 2'd1,
    ST_RUN   = 2'd2,
    ST_FAULT = 2'd3
  } supState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrAll;    // force ramp and filter to zero
    logic step;      // advance the ramp by one
    logic softNext;  // next state is soft start
    logic runNext;   // next state is run
  } ctlStrobe_t;

endpackage

// File: rtl/bsg_sync.sv
module bsg_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain[0] <= '0;
    else       chain[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : gStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain[s] <= '0;
      else       chain[s] <= chain[s-1];
    end
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/bsg_ctrl.sv
module bsg_ctrl
  import bsg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       supSync,
  input  logic       offSync,
  input  logic       rampTop,
  input  logic       uvTrip,
  output ctlStrobe_t strb,
  output logic       drvEn,
  output logic       faultOut,
  output logic       rampDone
);
  supState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_OFF:   if (supSync && !offSync) stateD = ST_SOFT;
      ST_SOFT: begin
        if (!supSync)             stateD = ST_OFF;
        else if (uvTrip)          stateD = ST_FAULT;
        else if (offSync)         stateD = ST_OFF;
        else if (tick && rampTop) stateD = ST_RUN;
      end
      ST_RUN: begin
        if (!supSync)     stateD = ST_OFF;
        else if (uvTrip)  stateD = ST_FAULT;
        else if (offSync) stateD = ST_OFF;
      end
      ST_FAULT: if (!supSync) stateD = ST_OFF;
      default:  stateD = ST_OFF;
    endcase
  end

  always_comb begin
    strb.clrAll   = (stateD == ST_OFF) || (stateD == ST_FAULT);
    strb.step     = (stateQ == ST_SOFT) && (stateD == ST_SOFT) && tick;
    strb.softNext = (stateD == ST_SOFT);
    strb.runNext  = (stateD == ST_RUN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_OFF;
      drvEn    <= 1'b0;
      faultOut <= 1'b0;
      rampDone <= 1'b0;
    end else begin
      stateQ   <= stateD;
      drvEn    <= (stateD == ST_SOFT) || (stateD == ST_RUN);
      faultOut <= (stateD == ST_FAULT);
      rampDone <= (stateD == ST_RUN);
    end
  end

  AST_OFF_ON_LOW_SUPPLY: assert property (@(posedge clk) disable iff (!rstN)
    !supSync |=> (!drvEn && !faultOut)); // R2
  AST_SHUTDOWN_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    (offSync && !faultOut && !uvTrip) |=> !drvEn); // R4
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (faultOut && supSync) |=> faultOut); // R8
  AST_FAULT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    faultOut |-> (!drvEn && !rampDone)); // R8
  AST_DONE_WITH_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    rampDone |-> drvEn); // R3
endmodule

// File: rtl/bsg_dpath.sv
module bsg_dpath
  import bsg_pkg::*;
#(
  parameter int REF_W  = 10,
  parameter int FILT_N = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             uvFlag,
  input  ctlStrobe_t       strb,
  output logic             rampTop,
  output logic             uvTrip,
  output logic [REF_W-1:0] refCode,
  output logic [REF_W-1:0] uvThresh,
  output logic             uvArmed
);
  localparam logic [REF_W-1:0] REF_MAX  = {REF_W{1'b1}};
  localparam logic [REF_W-1:0] REF_HALF = REF_W'(1) << (REF_W-1);
  localparam int               FW       = $clog2(FILT_N + 1);
  localparam logic [FW-1:0]    FILT_TOP = FW'(FILT_N - 1);

  logic [REF_W-1:0] countQ, countD;
  logic [FW-1:0]    filtQ, filtD;

  always_comb begin
    countD = countQ;
    if (strb.clrAll)    countD = '0;
    else if (strb.step) countD = countQ + 1'b1;
  end

  assign rampTop = (countQ == REF_MAX);
  assign uvTrip  = tick && uvArmed && uvFlag && (filtQ == FILT_TOP);

  always_comb begin
    filtD = filtQ;
    if (strb.clrAll || !uvArmed) filtD = '0;
    else if (tick) begin
      if (!uvFlag)                filtD = '0;
      else if (filtQ != FILT_TOP) filtD = filtQ + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ   <= '0;
      filtQ    <= '0;
      uvArmed  <= 1'b0;
      uvThresh <= '0;
    end else begin
      countQ   <= countD;
      filtQ    <= filtD;
      uvArmed  <= strb.runNext || (strb.softNext && (countD >= REF_HALF));
      uvThresh <= countD >> 1;
    end
  end

  assign refCode = countQ;

  AST_RAMP_UNIT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (countQ != $past(countQ)) |-> ((countQ == $past(countQ) + 1'b1) || (countQ == '0))); // R3
  AST_ARM_UPPER_HALF: assert property (@(posedge clk) disable iff (!rstN)
    uvArmed |-> (countQ >= REF_HALF)); // R5
  AST_THRESH_TRACKS: assert property (@(posedge clk) disable iff (!rstN)
    uvThresh == (countQ >> 1)); // R6
  AST_FILT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    filtQ <= FILT_TOP); // R7
endmodule

// File: rtl/buck_startup_guard.sv
module buck_startup_guard
  import bsg_pkg::*;
#(
  parameter int REF_W  = 10,
  parameter int FILT_N = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cycTick,
  input  logic             supplyOk,
  input  logic             offReq,
  input  logic             uvFlag,
  output logic [REF_W-1:0] refCode,
  output logic [REF_W-1:0] uvThresh,
  output logic             uvArmed,
  output logic             drvEn,
  output logic             faultOut,
  output logic             rampDone
);
  logic [1:0] syncBits;
  logic       rampTop, uvTrip;
  ctlStrobe_t strb;

  bsg_sync #(.WIDTH(2), .STAGES(2)) uSync (
    .clk(clk), .rstN(rstN),
    .asyncIn({supplyOk, offReq}),
    .syncOut(syncBits)
  );

  bsg_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .tick(cycTick),
    .supSync(syncBits[1]), .offSync(syncBits[0]),
    .rampTop(rampTop), .uvTrip(uvTrip), .strb(strb),
    .drvEn(drvEn), .faultOut(faultOut), .rampDone(rampDone)
  );

  bsg_dpath #(.REF_W(REF_W), .FILT_N(FILT_N)) uDpath (
    .clk(clk), .rstN(rstN), .tick(cycTick), .uvFlag(uvFlag),
    .strb(strb), .rampTop(rampTop), .uvTrip(uvTrip),
    .refCode(refCode), .uvThresh(uvThresh), .uvArmed(uvArmed)
  );
endmodule

// File: tb/sim_buck_startup_guard.sv
module sim_buck_startup_guard;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic cycTick = 1'b0, supplyOk = 1'b0, offReq = 1'b0, uvFlag = 1'b0;
  logic [9:0] refCode, uvThresh;
  logic uvArmed, drvEn, faultOut, rampDone;
  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  buck_startup_guard u0 (
    .clk(clk), .rstN(rstN), .cycTick(cycTick), .supplyOk(supplyOk),
    .offReq(offReq), .uvFlag(uvFlag), .refCode(refCode), .uvThresh(uvThresh),
    .uvArmed(uvArmed), .drvEn(drvEn), .faultOut(faultOut), .rampDone(rampDone)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) cycTick = 1'b1;
      @(negedge clk) cycTick = 1'b0;
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic power_cycle();
    @(negedge clk) supplyOk = 1'b0; uvFlag = 1'b0; offReq = 1'b0;
    settle();
    @(negedge clk) supplyOk = 1'b1;
    settle();
  endtask

  task automatic t_reset();
    chk("R1", "drvEn", drvEn, 0);
    chk("R1", "refCode", refCode, 0);
    chk("R1", "fault", faultOut, 0);
    chk("R1", "armed", uvArmed, 0);
    chk("R1", "done", rampDone, 0);
  endtask

  task automatic t_supply_low();
    ticks(5);
    chk("R2", "drvEn supply low", drvEn, 0);
    chk("R2", "refCode supply low", refCode, 0);
  endtask

  task automatic t_sync_latency();
    @(negedge clk) supplyOk = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R9", "drvEn after 2 edges", drvEn, 0);
    @(negedge clk);
    chk("R9", "drvEn after 3 edges", drvEn, 1);
    chk("R3", "ramp starts at 0", refCode, 0);
  endtask

  task automatic t_ramp_and_short();
    ticks(10);
    chk("R3", "refCode after 10 ticks", refCode, 10);
    chk("R6", "threshold at 10", uvThresh, 5);
    uvFlag = 1'b1;
    ticks(501);
    chk("R5", "refCode 511", refCode, 511);
    chk("R5", "armed at 511", uvArmed, 0);
    chk("R5", "no fault in low half", faultOut, 0);
    ticks(1);
    chk("R5", "armed at 512", uvArmed, 1);
    chk("R6", "threshold at 512", uvThresh, 256);
    ticks(7);
    chk("R7", "no trip after 7", faultOut, 0);
    chk("R3", "refCode 519", refCode, 519);
    ticks(1);
    chk("R7", "trip on 8th", faultOut, 1);
    chk("R8", "drvEn in fault", drvEn, 0);
    chk("R8", "refCode in fault", refCode, 0);
  endtask

  task automatic t_fault_sticky();
    uvFlag = 1'b0;
    @(negedge clk) offReq = 1'b1;
    settle();
    @(negedge clk) offReq = 1'b0;
    settle();
    ticks(4);
    chk("R8", "fault holds", faultOut, 1);
    chk("R8", "drvEn stays off", drvEn, 0);
    power_cycle();
    chk("R8", "fault cleared", faultOut, 0);
    chk("R8", "restart drvEn", drvEn, 1);
    chk("R8", "restart refCode", refCode, 0);
  endtask

  task automatic t_run_and_filter();
    ticks(1023);
    chk("R3", "refCode top", refCode, 1023);
    chk("R3", "done at top", rampDone, 0);
    ticks(1);
    chk("R3", "done in run", rampDone, 1);
    ticks(3);
    chk("R3", "hold in run", refCode, 1023);
    chk("R6", "threshold at top", uvThresh, 511);
    uvFlag = 1'b1; ticks(7);
    uvFlag = 1'b0; ticks(1);
    uvFlag = 1'b1; ticks(7);
    chk("R7", "broken run no trip", faultOut, 0);
    ticks(1);
    chk("R7", "trip after reset run", faultOut, 1);
    chk("R8", "done cleared", rampDone, 0);
    power_cycle();
  endtask

  task automatic t_shutdown();
    ticks(20);
    chk("R4", "ramp before off", refCode, 20);
    @(negedge clk) offReq = 1'b1;
    settle();
    chk("R4", "drvEn in shutdown", drvEn, 0);
    chk("R4", "refCode in shutdown", refCode, 0);
    ticks(5);
    chk("R4", "held while off", refCode, 0);
    @(negedge clk) offReq = 1'b0;
    settle();
    chk("R4", "drvEn restart", drvEn, 1);
    ticks(3);
    chk("R4", "new ramp", refCode, 3);
    chk("R4", "fault stays clear", faultOut, 0);
  endtask

  task automatic t_supply_drop_run();
    @(negedge clk) supplyOk = 1'b0;
    settle();
    chk("R2", "drvEn on drop", drvEn, 0);
    chk("R2", "refCode on drop", refCode, 0);
    chk("R2", "no fault on drop", faultOut, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_supply_low();
    t_sync_latency();
    t_ramp_and_short();
    t_fault_sticky();
    t_run_and_filter();
    t_shutdown();
    t_supply_drop_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=expired expected=complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule